// File: doc/BRIEF.md
# Raster Refresh Address Generator

This block produces the sequence of frame-buffer word addresses that a display refresh engine fetches while painting a raster. A character-clock enable advances it by one word per character position, an end-of-scan-line strobe moves it to the next line, and a frame start pulse restarts it at a programmable start address. Every character clock yields one address, and a valid strobe marks the positions that fall inside the visible width.

The number of words fetched on a line (the width) is set apart from the distance between line bases in memory (the pitch). A row of text can be drawn from the same line base over several scan lines, and a row-scan counter tells the font logic which scan line of the row is being drawn. A compare value can force the base back to address zero at a chosen scan line, which draws the lower part of a split screen from the start of memory. A final shifter moves each address left by zero, one or two bits, so that refresh touches only every second or every fourth word of an interleaved buffer.

Top module: `refresh_addr_gen`

## Requirements
- R1: Reset clears all internal state, so `addr_o` is 0, `row_scan_o` is 0 and no valid is given. A frame start pulse loads the word counter and line base with `cfg_start_addr` and clears the scan line and row-scan counters.
- R2: On each `char_en` cycle without a strobe, the word counter rises by one. With `char_en` low and no strobe, it holds.
- R3: When the row-scan counter wraps on `line_end`, the line base rises by `cfg_pitch`, whatever `cfg_width` is. Every `line_end` reloads the word counter from the new line base.
- R4: `row_scan_o` counts 0 up to `cfg_row_last` on successive `line_end` strobes, then returns to 0. The line base stays the same until that wrap.
- R5: The scan line number counts from 0 at frame start. When the number of the line being entered equals `cfg_line_cmp`, the line base and word counter load 0 and `row_scan_o` returns to 0. This also applies at frame start when the compare value is 0.
- R6: `addr_o` is the word counter shifted left according to `cfg_shift`: 0 gives no shift, 1 gives one bit and 2 gives two bits. Code 3 acts as code 2. The result is truncated to 16 bits, so addresses wrap modulo 2^16.
- R7: `addr_vld_o` is high only during `char_en` cycles and only for the first `cfg_width` character clocks of a scan line. A width of 0 gives no valid at all.
- R8: In any cycle, `frame_start` takes priority over `line_end`. In a cycle carrying either strobe, the word counter does not advance and `addr_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character-clock enable |
| line_end | input | 1 | End-of-scan-line strobe |
| frame_start | input | 1 | Frame restart pulse |
| cfg_start_addr | input | 16 | Word address of the first line |
| cfg_pitch | input | 16 | Word distance between line bases |
| cfg_width | input | 8 | Visible character positions per line |
| cfg_row_last | input | 5 | Scan lines per row minus one |
| cfg_line_cmp | input | 10 | Scan line at which the base returns to zero |
| cfg_shift | input | 2 | Address shift select |
| addr_o | output | 16 | Shifted refresh word address |
| addr_vld_o | output | 1 | Address valid |
| row_scan_o | output | 5 | Scan line within the current row |

## Verification
The embedded assertions assume two things: the configuration inputs stay constant while a frame is drawn, and valid addresses on back-to-back cycles belong to one scan line that uses a single shift setting. The stimulus changes configuration only in idle cycles just before a frame start pulse. It always separates the character clocks of two lines with a strobe cycle, so the assertions only see the conditions they assume. Within those limits, the stimulus covers start addresses near the top of the address space, a compare value of zero, shift code 3 and a width of zero.

// File: rtl/rag_pkg.sv
package rag_pkg;
    localparam int ADDR_W_DEF = 16;
    localparam int SCAN_W_DEF = 10;
    localparam int ROW_W_DEF  = 5;
    localparam int WID_W_DEF  = 8;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_ONE  = 2'd1,
        SH_TWO  = 2'd2,
        SH_TWOB = 2'd3
    } shift_e;

    // per-cycle line control handed from scan tracking to the address counter
    typedef struct packed {
        logic load;     // a strobe is present: reload counter from new base
        logic restart;  // frame start: base from start address
        logic advance;  // row wrapped: base moves by pitch
        logic split;    // entered line matches compare: base to zero
    } line_ctl_t;

    function automatic logic [ADDR_W_DEF-1:0] shift_word(
        input logic [ADDR_W_DEF-1:0] word,
        input shift_e                mode
    );
        case (mode)
            SH_NONE: shift_word = word;
            SH_ONE:  shift_word = word << 1;
            default: shift_word = word << 2;
        endcase
    endfunction
endpackage

// File: rtl/rag_scan_ctrl.sv
module rag_scan_ctrl
    import rag_pkg::*;
#(
    parameter int SCAN_W = SCAN_W_DEF,
    parameter int ROW_W  = ROW_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic [ROW_W-1:0]  cfg_row_last,
    input  logic [SCAN_W-1:0] cfg_line_cmp,
    output line_ctl_t         ctl,
    output logic [ROW_W-1:0]  row_scan
);
    logic [SCAN_W-1:0] scan_q;
    logic [SCAN_W-1:0] scan_next;
    logic              cmp_hit;
    logic              row_wrap;

    always_comb begin
        scan_next   = frame_start ? '0 : scan_q + 1'b1;
        cmp_hit     = (scan_next == cfg_line_cmp);
        row_wrap    = (row_scan == cfg_row_last);
        ctl.load    = frame_start | line_end;
        ctl.restart = frame_start;
        ctl.advance = line_end & ~frame_start & row_wrap;
        ctl.split   = (frame_start | line_end) & cmp_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q   <= '0;
            row_scan <= '0;
        end else if (frame_start) begin
            scan_q   <= '0;
            row_scan <= '0;
        end else if (line_end) begin
            scan_q   <= scan_next;
            row_scan <= (cmp_hit || row_wrap) ? '0 : row_scan + 1'b1;
        end
    end

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_start && row_scan == cfg_row_last) |=> (row_scan == '0)); // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (line_end && !frame_start && !ctl.split && row_scan != cfg_row_last)
        |=> (row_scan == $past(row_scan) + 1'b1)); // R4
endmodule

// File: rtl/rag_addr_cnt.sv
module rag_addr_cnt
    import rag_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int WID_W  = WID_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_en,
    input  line_ctl_t         ctl,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [WID_W-1:0]  cfg_width,
    output logic [ADDR_W-1:0] word_cnt,
    output logic              vld
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] base_next;
    logic [WID_W-1:0]  pos_q;
    logic              in_width;

    always_comb begin
        if (ctl.split)        base_next = '0;
        else if (ctl.restart) base_next = cfg_start_addr;
        else if (ctl.advance) base_next = base_q + cfg_pitch;
        else                  base_next = base_q;
        in_width = (pos_q < cfg_width);
        vld      = char_en & ~ctl.load & in_width;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            word_cnt <= '0;
            pos_q    <= '0;
        end else if (ctl.load) begin
            base_q   <= base_next;
            word_cnt <= base_next;
            pos_q    <= '0;
        end else if (char_en) begin
            word_cnt <= word_cnt + 1'b1;
            if (in_width) pos_q <= pos_q + 1'b1;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!char_en && !ctl.load) |=> $stable(word_cnt)); // R2
    AST_STROBE_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        ctl.load |-> !vld); // R8
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
    import rag_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int SCAN_W = SCAN_W_DEF,
    parameter int ROW_W  = ROW_W_DEF,
    parameter int WID_W  = WID_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_en,
    input  logic              line_end,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cfg_start_addr,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [ROW_W-1:0]  cfg_row_last,
    input  logic [SCAN_W-1:0] cfg_line_cmp,
    input  logic [1:0]        cfg_shift,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o,
    output logic [ROW_W-1:0]  row_scan_o
);
    localparam int SHIFT_MAX = 2;

    line_ctl_t         ctl;
    logic [ADDR_W-1:0] word_cnt;

    rag_scan_ctrl #(.SCAN_W(SCAN_W), .ROW_W(ROW_W)) u_scan (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .line_end     (line_end),
        .cfg_row_last (cfg_row_last),
        .cfg_line_cmp (cfg_line_cmp),
        .ctl          (ctl),
        .row_scan     (row_scan_o)
    );

    rag_addr_cnt #(.ADDR_W(ADDR_W), .WID_W(WID_W)) u_cnt (
        .clk            (clk),
        .rst            (rst),
        .char_en        (char_en),
        .ctl            (ctl),
        .cfg_start_addr (cfg_start_addr),
        .cfg_pitch      (cfg_pitch),
        .cfg_width      (cfg_width),
        .word_cnt       (word_cnt),
        .vld            (addr_vld_o)
    );

    always_comb begin
        case (shift_e'(cfg_shift))
            SH_NONE: addr_o = word_cnt;
            SH_ONE:  addr_o = word_cnt << 1;
            default: addr_o = word_cnt << SHIFT_MAX;
        endcase
    end

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cfg_line_cmp != '0) |=> (word_cnt == $past(cfg_start_addr))); // R1
    AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.split |=> (word_cnt == '0 && row_scan_o == '0)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (addr_vld_o ##1 (addr_vld_o && cfg_shift == 2'd0 && $past(cfg_shift) == 2'd0))
        |-> (addr_o == $past(addr_o) + 1'b1)); // R2
    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (rst)
        (cfg_shift != 2'd0) |-> (addr_o[0] == 1'b0)); // R6
    AST_SHIFT_TWO: assert property (@(posedge clk) disable iff (rst)
        cfg_shift[1] |-> (addr_o[1:0] == 2'b00)); // R6
endmodule

// File: tb/tb_refresh_addr_gen.sv
module tb_refresh_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        char_en, line_end, frame_start;
    logic [15:0] cfg_start_addr, cfg_pitch;
    logic [7:0]  cfg_width;
    logic [4:0]  cfg_row_last;
    logic [9:0]  cfg_line_cmp;
    logic [1:0]  cfg_shift;
    logic [15:0] addr_o;
    logic        addr_vld_o;
    logic [4:0]  row_scan_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic [15:0] m_base, m_cnt;
    int          m_pos;
    logic [9:0]  m_scan;
    logic [4:0]  m_row;

    always #5 clk = ~clk;

    refresh_addr_gen dut (
        .clk(clk), .rst(rst), .char_en(char_en), .line_end(line_end),
        .frame_start(frame_start), .cfg_start_addr(cfg_start_addr),
        .cfg_pitch(cfg_pitch), .cfg_width(cfg_width), .cfg_row_last(cfg_row_last),
        .cfg_line_cmp(cfg_line_cmp), .cfg_shift(cfg_shift), .addr_o(addr_o),
        .addr_vld_o(addr_vld_o), .row_scan_o(row_scan_o)
    );

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] pitch;
        logic [7:0]  width;
        logic [4:0]  rlast;
        logic [9:0]  cmp;
        logic [1:0]  sh;
        logic [7:0]  lines;
    } scen_t;

    localparam scen_t SCN [4] = '{
        '{16'h0100, 16'd40, 8'd5, 5'd1, 10'd1023, 2'd0, 8'd6},
        '{16'h0010, 16'd8,  8'd4, 5'd0, 10'd3,    2'd1, 8'd6},
        '{16'hFFFC, 16'd10, 8'd3, 5'd2, 10'd4,    2'd2, 8'd7},
        '{16'h0000, 16'd20, 8'd6, 5'd3, 10'd0,    2'd3, 8'd5}
    };

    function automatic logic [15:0] exp_shift(input logic [15:0] w, input logic [1:0] s);
        if (s == 2'd0)      return w;
        else if (s == 2'd1) return w << 1;
        else                return w << 2;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_update(input bit fs, input bit le, input bit ce);
        logic [9:0]  nscan;
        logic [15:0] nbase;
        bit          hit;
        if (fs || le) begin
            nscan = fs ? 10'd0 : m_scan + 10'd1;
            hit   = (nscan == cfg_line_cmp);
            if (hit)     nbase = '0;
            else if (fs) nbase = cfg_start_addr;
            else if (m_row == cfg_row_last) nbase = m_base + cfg_pitch;
            else nbase = m_base;
            if (fs)                              m_row = '0;
            else if (hit || m_row == cfg_row_last) m_row = '0;
            else                                 m_row = m_row + 5'd1;
            m_scan = nscan;
            m_base = nbase;
            m_cnt  = nbase;
            m_pos  = 0;
        end else if (ce) begin
            m_cnt = m_cnt + 16'd1;
            if (m_pos < int'(cfg_width)) m_pos++;
        end
    endtask

    // drive at negedge, sample 1 ns later, then update the reference
    task automatic step(input bit fs, input bit le, input bit ce);
        bit exp_vld;
        frame_start = fs; line_end = le; char_en = ce;
        #1;
        exp_vld = ce && !fs && !le && (m_pos < int'(cfg_width));
        check(addr_vld_o == exp_vld, "R7 R8 valid", addr_vld_o, exp_vld);
        if (exp_vld)
            check(addr_o == exp_shift(m_cnt, cfg_shift), "R2 R3 R6 address",
                  addr_o, exp_shift(m_cnt, cfg_shift));
        check(row_scan_o == m_row, "R4 row scan", row_scan_o, m_row);
        model_update(fs, le, ce);
        @(negedge clk);
    endtask

    task automatic set_cfg(input scen_t s);
        cfg_start_addr = s.start; cfg_pitch = s.pitch; cfg_width = s.width;
        cfg_row_last = s.rlast; cfg_line_cmp = s.cmp; cfg_shift = s.sh;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; char_en = 0; line_end = 0; frame_start = 0;
        set_cfg(SCN[0]);
        m_base = '0; m_cnt = '0; m_pos = 0; m_scan = '0; m_row = '0;
        repeat (3) @(negedge clk);
        #1;
        check(addr_o == 16'h0, "R1 reset address", addr_o, 0);
        check(row_scan_o == 5'd0, "R1 reset row", row_scan_o, 0);
        check(addr_vld_o == 1'b0, "R1 reset valid", addr_vld_o, 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: one frame per scenario
        for (int i = 0; i < 4; i++) begin
            set_cfg(SCN[i]);
            step(0, 0, 0);
            step(1, 0, 0);
            for (int ln = 0; ln < int'(SCN[i].lines); ln++) begin
                for (int c = 0; c < int'(SCN[i].width) + 2; c++) step(0, 0, 1);
                step(0, 0, 0);
                step(0, 1, 0);
            end
        end

        // R1: first address after frame start equals start address
        set_cfg('{16'h0420, 16'd16, 8'd4, 5'd0, 10'd2, 2'd0, 8'd0});
        step(0, 0, 0);
        step(1, 0, 0);
        #1; check(addr_o == 16'h0420, "R1 frame start address", addr_o, 16'h0420);
        step(0, 0, 1);
        step(0, 1, 0);
        #1; check(addr_o == 16'h0430, "R3 base plus pitch", addr_o, 16'h0430);
        step(0, 1, 0);
        #1; check(addr_o == 16'h0000, "R5 split to zero", addr_o, 0);
        check(row_scan_o == 5'd0, "R5 split row", row_scan_o, 0);
        step(0, 0, 1);

        // R8: frame start wins over line end in the same cycle
        step(0, 0, 1);
        step(1, 1, 1);
        #1; check(addr_o == 16'h0420, "R8 frame start priority", addr_o, 16'h0420);
        check(row_scan_o == 5'd0, "R8 row after priority", row_scan_o, 0);

        // R2: counter holds with char_en low
        step(0, 0, 1);
        step(0, 0, 0);
        step(0, 0, 0);
        #1; check(addr_o == 16'h0421, "R2 hold when idle", addr_o, 16'h0421);

        // R6: shift code 3 behaves as code 2, wrap modulo 2^16
        cfg_shift = 2'd3;
        step(0, 0, 0);
        #1; check(addr_o == 16'h1084, "R6 shift code 3", addr_o, 16'h1084);
        cfg_start_addr = 16'hFFFF; cfg_shift = 2'd1;
        step(1, 0, 0);
        #1; check(addr_o == 16'hFFFE, "R6 wrap after shift", addr_o, 16'hFFFE);
        step(0, 0, 1);
        #1; check(addr_o == 16'h0000, "R6 counter wrap", addr_o, 0);

        // R7: width zero never gives a valid
        cfg_width = 8'd0;
        step(0, 0, 0);
        step(1, 0, 0);
        for (int c = 0; c < 4; c++) step(0, 0, 1);
        check(addr_vld_o == 1'b0, "R7 width zero", addr_vld_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule